// File: doc/BRIEF.md
# Link Frame Builder with CRC-16

The block assembles outgoing link frames for a byte-wide UART transmitter. The client first streams the payload into an internal buffer, one byte per handshake. It then commits the frame with a type byte and a sequence byte. Because the whole payload is held before anything goes out, the total frame length is known in advance and is emitted first. The remaining bytes follow in a fixed order, and the 16-bit checksum is computed on the fly and appended last.

On a commit, the builder refuses two kinds of request: a type code in the reserved window, and a payload too large for the largest legal frame. A refused request produces no frame, pulses an error output for one cycle and empties the buffer. Once a frame has started, the builder accepts neither payload bytes nor commits until the frame is finished. The downstream ready signal may stall the byte stream at any point without changing it. A one-cycle done pulse marks the end of each frame.

Top module: `lnk_frame_tx`

## Requirements
- R1: A frame goes out in this order: length low byte, length high byte, type, sequence, payload bytes in arrival order, checksum low byte, checksum high byte. Type and sequence are passed through unchanged; a sequence of 0 and sequences 1..255 are treated alike.
- R2: The 16-bit length field equals the payload byte count plus 6, so an empty payload gives 0x0006, and it is sent little-endian.
- R3: The checksum is CRC-16 with polynomial 0x1021, initial value 0xFFFF, MSB-first, no reflection and no final XOR. It covers type, sequence and payload only and is sent little-endian. Over the bytes "123456789" it gives 0x29B1.
- R4: A commit whose type lies in 0x10..0x16 inclusive starts no frame. `err_o` is high for exactly the cycle after the commit. Types 0x0F and 0x17 are accepted normally.
- R5: The buffer holds up to 1018 payload bytes, which makes a 1024-byte frame (length 0x0400). Bytes beyond 1018 are still accepted but discarded, and the commit that follows is refused as in R4.
- R6: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` holds its value, so no byte is lost or duplicated.
- R7: While a frame is being sent, `pl_ready_o` and `cmd_ready_o` are low.
- R8: `done_o` is high for exactly one cycle: the cycle after the checksum high byte is accepted downstream.
- R9: After reset, `tx_valid_o`, `err_o` and `done_o` are low, and `cmd_ready_o` and `pl_ready_o` are high.
- R10: After a completed or refused frame the buffer is empty, so the next frame contains only the bytes pushed after it.
- R11: When `cmd_valid_i` is high, `pl_ready_o` is low. A payload byte offered in the same cycle as a commit is therefore not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pl_valid_i | input | 1 | Payload byte offered |
| pl_data_i | input | 8 | Payload byte |
| pl_ready_o | output | 1 | Payload byte taken when high with pl_valid_i |
| cmd_valid_i | input | 1 | Commit request |
| cmd_type_i | input | 8 | Frame type |
| cmd_seq_i | input | 8 | Sequence number |
| cmd_ready_o | output | 1 | Builder idle, commit taken |
| tx_valid_o | output | 1 | Output byte valid |
| tx_data_o | output | 8 | Output byte |
| tx_ready_i | input | 1 | Transmitter takes the byte |
| err_o | output | 1 | One-cycle pulse on a refused commit |
| done_o | output | 1 | One-cycle pulse after the last frame byte |

## Verification
The hold check on the output stream assumes the client does not change the buffer while a frame is in flight. The design itself enforces this by dropping `pl_ready_o`. The done and error checks assume a commit is only counted when `cmd_ready_o` is high. The bench applies every input at the falling edge and releases the commit after one accepted cycle. It drives three downstream ready patterns (always ready, two of three, alternate) so that stalls land on header, payload and checksum bytes alike. Payload sizes are kept at the empty, mid, maximum and one-over-maximum points.

// File: rtl/lnk_frame_pkg.sv
package lnk_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN_LO,
    ST_LEN_HI,
    ST_TYPE,
    ST_SEQ,
    ST_PAY,
    ST_CRC_LO,
    ST_CRC_HI
  } tx_state_e;

  // one byte through an MSB-first CRC-16
  function automatic logic [15:0] crc16_step(logic [15:0] crc, logic [7:0] data,
                                             logic [15:0] poly);
    logic [15:0] r;
    r = crc ^ {data, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/lnk_pl_buf.sv
module lnk_pl_buf #(
  parameter int DEPTH = 1018,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [7:0]    wr_data_i,
  input  logic          clear_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [CW-1:0] count_o,
  output logic          ovr_o,
  output logic [7:0]    rd_data_o
);

  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] count_q;
  logic          ovr_q;
  logic          full;

  assign full = (count_q == CW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !full) mem_q[count_q[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      ovr_q   <= 1'b0;
    end else if (clear_i) begin
      count_q <= '0;
      ovr_q   <= 1'b0;
    end else if (wr_en_i) begin
      if (full) ovr_q <= 1'b1;
      else      count_q <= count_q + CW'(1);
    end
  end

  assign count_o   = count_q;
  assign ovr_o     = ovr_q;
  assign rd_data_o = mem_q[rd_idx_i];

  AST_OVR_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> full); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_q == '0) && !ovr_q); // R10

endmodule

// File: rtl/lnk_crc16.sv
module lnk_crc16 #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  import lnk_frame_pkg::*;

  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT;
    else if (init_i) crc_q <= INIT;
    else if (en_i)   crc_q <= crc16_step(crc_q, data_i, POLY);
  end

  assign crc_o = crc_q;

  AST_CRC_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> crc_q == INIT); // R3

endmodule

// File: rtl/lnk_frame_seq.sv
module lnk_frame_seq #(
  parameter int          MAX_PL = 1018,
  parameter int          AW     = $clog2(MAX_PL),
  parameter int          CW     = $clog2(MAX_PL + 1),
  parameter logic [7:0]  RSV_LO = 8'h10,
  parameter logic [7:0]  RSV_HI = 8'h16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_type_i,
  input  logic [7:0]    cmd_seq_i,
  output logic          cmd_ready_o,
  input  logic [CW-1:0] pl_count_i,
  input  logic          pl_ovr_i,
  input  logic [7:0]    pl_data_i,
  output logic [AW-1:0] rd_idx_o,
  input  logic [15:0]   crc_i,
  output logic          crc_init_o,
  output logic          crc_en_o,
  output logic          buf_clear_o,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_ready_i,
  output logic          err_o,
  output logic          done_o
);
  import lnk_frame_pkg::*;

  localparam int OVH = 6;

  tx_state_e     state_q, state_d;
  logic [7:0]    type_q, seq_q;
  logic [CW-1:0] rd_idx_q;
  logic          err_q, done_q;
  logic          cmd_fire, tx_fire, bad, last_pl;
  logic [15:0]   len;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign tx_valid_o  = (state_q != ST_IDLE);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign tx_fire     = tx_valid_o && tx_ready_i;
  assign bad         = pl_ovr_i || ((cmd_type_i >= RSV_LO) && (cmd_type_i <= RSV_HI));
  assign len         = 16'(pl_count_i) + 16'(OVH);
  assign last_pl     = (rd_idx_q == pl_count_i - CW'(1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (cmd_fire && !bad) state_d = ST_LEN_LO;
      ST_LEN_LO: if (tx_fire) state_d = ST_LEN_HI;
      ST_LEN_HI: if (tx_fire) state_d = ST_TYPE;
      ST_TYPE:   if (tx_fire) state_d = ST_SEQ;
      ST_SEQ:    if (tx_fire) state_d = (pl_count_i == '0) ? ST_CRC_LO : ST_PAY;
      ST_PAY:    if (tx_fire && last_pl) state_d = ST_CRC_LO;
      ST_CRC_LO: if (tx_fire) state_d = ST_CRC_HI;
      ST_CRC_HI: if (tx_fire) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_LEN_LO: tx_data_o = len[7:0];
      ST_LEN_HI: tx_data_o = len[15:8];
      ST_TYPE:   tx_data_o = type_q;
      ST_SEQ:    tx_data_o = seq_q;
      ST_PAY:    tx_data_o = pl_data_i;
      ST_CRC_LO: tx_data_o = crc_i[7:0];
      ST_CRC_HI: tx_data_o = crc_i[15:8];
      default:   tx_data_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      type_q   <= '0;
      seq_q    <= '0;
      rd_idx_q <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= cmd_fire && bad;
      done_q  <= tx_fire && (state_q == ST_CRC_HI);
      if (cmd_fire) begin
        type_q   <= cmd_type_i;
        seq_q    <= cmd_seq_i;
        rd_idx_q <= '0;
      end else if (tx_fire && state_q == ST_PAY) begin
        rd_idx_q <= rd_idx_q + CW'(1);
      end
    end
  end

  assign rd_idx_o    = rd_idx_q[AW-1:0];
  assign crc_init_o  = cmd_fire;
  assign crc_en_o    = tx_fire && (state_q inside {ST_TYPE, ST_SEQ, ST_PAY});
  assign buf_clear_o = (cmd_fire && bad) || (tx_fire && state_q == ST_CRC_HI);
  assign err_o       = err_q;
  assign done_o      = done_q;

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)); // R6
  AST_ERR_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !tx_valid_o); // R4
  AST_DONE_AFTER_CRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q == ST_CRC_HI && tx_ready_i)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LEN_LO |-> len >= 16'(OVH) && len <= 16'(MAX_PL + OVH)); // R2

endmodule

// File: rtl/lnk_frame_tx.sv
module lnk_frame_tx #(
  parameter int         MAX_FRAME = 1024,
  parameter logic [7:0] RSV_LO    = 8'h10,
  parameter logic [7:0] RSV_HI    = 8'h16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pl_valid_i,
  input  logic [7:0] pl_data_i,
  output logic       pl_ready_o,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_type_i,
  input  logic [7:0] cmd_seq_i,
  output logic       cmd_ready_o,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  input  logic       tx_ready_i,
  output logic       err_o,
  output logic       done_o
);

  localparam int MAX_PL = MAX_FRAME - 6;
  localparam int AW     = $clog2(MAX_PL);
  localparam int CW     = $clog2(MAX_PL + 1);

  logic [CW-1:0] pl_count;
  logic          pl_ovr, buf_clear, crc_init, crc_en;
  logic [7:0]    rd_data;
  logic [AW-1:0] rd_idx;
  logic [15:0]   crc;
  logic          wr_en;

  assign pl_ready_o = cmd_ready_o && !cmd_valid_i;
  assign wr_en      = pl_valid_i && pl_ready_o;

  lnk_pl_buf #(.DEPTH(MAX_PL), .AW(AW), .CW(CW)) i_buf (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_data_i (pl_data_i),
    .clear_i   (buf_clear),
    .rd_idx_i  (rd_idx),
    .count_o   (pl_count),
    .ovr_o     (pl_ovr),
    .rd_data_o (rd_data)
  );

  lnk_crc16 i_crc (
    .clk_i, .rst_ni,
    .init_i (crc_init),
    .en_i   (crc_en),
    .data_i (tx_data_o),
    .crc_o  (crc)
  );

  lnk_frame_seq #(.MAX_PL(MAX_PL), .AW(AW), .CW(CW), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) i_seq (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_type_i, .cmd_seq_i, .cmd_ready_o,
    .pl_count_i  (pl_count),
    .pl_ovr_i    (pl_ovr),
    .pl_data_i   (rd_data),
    .rd_idx_o    (rd_idx),
    .crc_i       (crc),
    .crc_init_o  (crc_init),
    .crc_en_o    (crc_en),
    .buf_clear_o (buf_clear),
    .tx_valid_o, .tx_data_o, .tx_ready_i,
    .err_o, .done_o
  );

  AST_NO_INTERLEAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !pl_ready_o && !cmd_ready_o); // R7
  AST_COMMIT_BLOCKS_PL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> !pl_ready_o); // R11

endmodule

// File: tb/test_lnk_frame_tx.sv
module test_lnk_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pl_valid = 1'b0;
  logic [7:0] pl_data = '0;
  logic       pl_ready;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_type = '0;
  logic [7:0] cmd_seq = '0;
  logic       cmd_ready;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;
  logic       err;
  logic       done;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] pl_tb [0:1023];
  logic [7:0] exp_b [0:1031];
  logic [7:0] rx_b  [0:1031];

  always #5 clk = ~clk;

  lnk_frame_tx i_lnk_frame_tx (
    .clk_i(clk), .rst_ni(rst_n),
    .pl_valid_i(pl_valid), .pl_data_i(pl_data), .pl_ready_o(pl_ready),
    .cmd_valid_i(cmd_valid), .cmd_type_i(cmd_type), .cmd_seq_i(cmd_seq),
    .cmd_ready_o(cmd_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .err_o(err), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_ref(input int first, input int last);
    logic [15:0] c = 16'hFFFF;
    for (int i = first; i <= last; i++) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ exp_b[i][b];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic build_exp(input logic [7:0] t, input logic [7:0] s, input int npl);
    logic [15:0] len = 16'(npl + 6);
    logic [15:0] c;
    exp_b[0] = len[7:0];
    exp_b[1] = len[15:8];
    exp_b[2] = t;
    exp_b[3] = s;
    for (int i = 0; i < npl; i++) exp_b[4 + i] = pl_tb[i];
    c = crc_ref(2, 3 + npl);
    exp_b[4 + npl] = c[7:0];
    exp_b[5 + npl] = c[15:8];
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) pl_tb[i] = 8'((i * 7 + seed) & 255);
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pl_valid = 1'b1;
      pl_data  = pl_tb[i];
    end
    @(negedge clk);
    pl_valid = 1'b0;
  endtask

  // leaves the bench at the negedge after the commit has been taken
  task automatic commit(input logic [7:0] t, input logic [7:0] s);
    cmd_valid = 1'b1;
    cmd_type  = t;
    cmd_seq   = s;
    #1;
    chk(cmd_ready === 1'b1, "R7 cmd_ready before commit", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic receive(input int npl, input int mode, input string tag);
    int n = npl + 6;
    int k = 0;
    int cyc = 0;
    int bad_body = 0, bad_hold = 0, bad_busy = 0;
    bit held = 0;
    logic [7:0] prev = '0;
    while (k < n && cyc < 5000) begin
      case (mode)
        1:       tx_ready = (cyc % 3) != 2;
        2:       tx_ready = cyc[0];
        default: tx_ready = 1'b1;
      endcase
      #1;
      if (tx_valid !== 1'b1 || pl_ready !== 1'b0 || cmd_ready !== 1'b0) bad_busy++;
      if (held && tx_data !== prev) bad_hold++;
      if (tx_ready) begin
        rx_b[k] = tx_data;
        k++;
        held = 0;
      end else begin
        held = 1;
        prev = tx_data;
      end
      @(negedge clk);
      cyc++;
    end
    tx_ready = 1'b0;
    chk(k == n, {"R1 byte count ", tag}, k, n);
    for (int i = 2; i < n - 2; i++) if (rx_b[i] !== exp_b[i]) bad_body++;
    chk(bad_body == 0, {"R1 type/seq/payload mismatches ", tag}, bad_body, 0);
    chk({rx_b[1], rx_b[0]} === {exp_b[1], exp_b[0]}, {"R2 length ", tag},
        int'({rx_b[1], rx_b[0]}), int'({exp_b[1], exp_b[0]}));
    chk({rx_b[n-1], rx_b[n-2]} === {exp_b[n-1], exp_b[n-2]}, {"R3 crc ", tag},
        int'({rx_b[n-1], rx_b[n-2]}), int'({exp_b[n-1], exp_b[n-2]}));
    if (mode != 0) chk(bad_hold == 0, {"R6 stall hold ", tag}, bad_hold, 0);
    chk(bad_busy == 0, {"R7 busy handshake ", tag}, bad_busy, 0);
    chk(done === 1'b1, {"R8 done after last byte ", tag}, int'(done), 1);
    chk(tx_valid === 1'b0, {"R8 idle after frame ", tag}, int'(tx_valid), 0);
    @(negedge clk);
    chk(done === 1'b0, {"R8 done single cycle ", tag}, int'(done), 0);
  endtask

  task automatic t_reset;
    #1;
    chk(tx_valid === 1'b0, "R9 tx_valid", int'(tx_valid), 0);
    chk(cmd_ready === 1'b1, "R9 cmd_ready", int'(cmd_ready), 1);
    chk(pl_ready === 1'b1, "R9 pl_ready", int'(pl_ready), 1);
    chk(err === 1'b0 && done === 1'b0, "R9 err/done", int'({err, done}), 0);
  endtask

  task automatic t_vector;
    string s = "3456789";
    for (int i = 0; i < 7; i++) pl_tb[i] = s[i];
    build_exp(8'h31, 8'h32, 7);
    chk({exp_b[12], exp_b[11]} == 16'h29B1, "R3 reference vector", int'({exp_b[12], exp_b[11]}), 'h29B1);
    push(7);
    commit(8'h31, 8'h32);
    receive(7, 0, "vector");
    chk(rx_b[11] === 8'hB1 && rx_b[12] === 8'h29, "R3 check value 0x29B1",
        int'({rx_b[12], rx_b[11]}), 'h29B1);
    chk(rx_b[0] === 8'd13 && rx_b[1] === 8'd0, "R2 length 13", int'({rx_b[1], rx_b[0]}), 13);
  endtask

  task automatic t_empty;
    build_exp(8'h21, 8'h00, 0);
    @(negedge clk);
    commit(8'h21, 8'h00);
    receive(0, 2, "empty");
    chk(rx_b[0] === 8'h06, "R2 empty length 6", int'(rx_b[0]), 6);
  endtask

  task automatic t_reserved(input logic [7:0] t);
    fill(3, 11);
    push(3);
    commit(t, 8'h01);
    #1;
    chk(err === 1'b1, "R4 err pulse on reserved type", int'(err), 1);
    chk(tx_valid === 1'b0, "R4 no frame on reserved type", int'(tx_valid), 0);
    @(negedge clk);
    #1;
    chk(err === 1'b0 && tx_valid === 1'b0, "R4 err single cycle", int'({err, tx_valid}), 0);
  endtask

  task automatic t_edges;
    build_exp(8'h0F, 8'h07, 0);
    @(negedge clk);
    commit(8'h0F, 8'h07);
    receive(0, 1, "type 0x0F after refusal R10");
    fill(2, 99);
    build_exp(8'h17, 8'hFF, 2);
    push(2);
    commit(8'h17, 8'hFF);
    receive(2, 2, "type 0x17");
  endtask

  task automatic t_max;
    fill(1018, 3);
    build_exp(8'h30, 8'h00, 1018);
    push(1018);
    commit(8'h30, 8'h00);
    receive(1018, 1, "max payload R5");
    chk({rx_b[1], rx_b[0]} === 16'h0400, "R5 length 0x0400", int'({rx_b[1], rx_b[0]}), 'h400);
  endtask

  task automatic t_overrun;
    fill(1019, 5);
    push(1019);
    commit(8'h22, 8'h00);
    #1;
    chk(err === 1'b1, "R5 err on 1019-byte payload", int'(err), 1);
    chk(tx_valid === 1'b0, "R5 no frame on overrun", int'(tx_valid), 0);
    fill(4, 200);
    build_exp(8'h03, 8'h09, 4);
    push(4);
    commit(8'h03, 8'h09);
    receive(4, 0, "after overrun R10");
  endtask

  task automatic t_collide;
    fill(2, 40);
    build_exp(8'h33, 8'h02, 2);
    push(2);
    pl_valid  = 1'b1;
    pl_data   = 8'hEE;
    cmd_valid = 1'b1;
    cmd_type  = 8'h33;
    cmd_seq   = 8'h02;
    #1;
    chk(pl_ready === 1'b0, "R11 pl_ready low during commit", int'(pl_ready), 0);
    @(negedge clk);
    pl_valid  = 1'b0;
    cmd_valid = 1'b0;
    receive(2, 0, "collide R11");
  endtask

  initial begin
    #(10 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vector();
    t_empty();
    t_reserved(8'h10);
    t_reserved(8'h16);
    t_edges();
    t_max();
    t_overrun();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule